// File: doc/BRIEF.md
# Buffered Compare/Capture Timer Channel

This block is one 16-bit timer channel. A counter advances on cycles where a chosen count-enable source is high. Four general registers sit beside the counter, and each one can work in one of two ways. As a compare register, it changes its own output pin when the counter reaches its value. As a capture register, it stores the counter value when a chosen edge appears on its own input pin.

Two of the four registers can also be paired with the other two as second-level buffers. In compare mode, the buffer holds the next period value, and that value loads on the match that ends the current period. In capture mode, the buffer keeps the previous capture, which gives two-deep capture history. The counter can be cleared by the event of any one register.

Each register has a sticky event flag, and the counter has a wrap flag. All registers are reached through a simple word-wide read/write port with a fixed one-cycle read latency.

Top module: `cct_timer`

Register addresses (bus_addr):
- 0: control.
  - [2:0] count-source select.
  - [6:4] clear source: 0 = none, 1..4 = register A..D event.
  - [8] C buffers A.
  - [9] D buffers B.
- 1: mode. Register i (A=0 .. D=3) uses nibble [4i+3:4i]:
  - bit 4i: 1 = capture, 0 = compare.
  - bits [4i+2:4i+1]: the code.
- 2: status. Bits [3:0] are the A..D event flags; bit 4 is the wrap flag.
- 3: counter.
- 4..7: registers A..D.

## Requirements
- R1: After reset, the following hold:
  - the counter and status read 0;
  - registers A..D read 0xFFFF;
  - every compare output is 0;
  - all flags are 0.
- R2: The counter increments on exactly those clock edges where tick_src[sel] is 1, with sel taken from control[2:0].
- R3: A compare register matches when the counter equals its value on a counting edge. On that edge its flag is set and its output applies the code: 00 = hold, 01 = drive 0, 10 = drive 1, 11 = toggle.
- R4: A capture register uses the code to select its edge: 01 = rising, 10 = falling, 11 = both, 00 = none. Other edges are ignored. The pin passes two synchroniser stages, so the stored value is the counter value two edges after the pin change.
- R5: When the control clear-source field selects a register, that register's match or capture sets the counter to 0 on the same edge.
- R6: When A (or B) is in compare mode and buffering is on, its match copies C (or D) into it. The buffer register then makes no events of its own.
- R7: When A (or B) is in capture mode and buffering is on, a capture moves A's old value into C (or D) while A takes the counter.
- R8: When the counter counts from 0xFFFF to 0, the wrap flag (status bit 4) is set.
- R9: On the counter, priorities run from highest to lowest:
  1. a clear event;
  2. a bus write;
  3. the increment.
- R10: Flags are sticky. Writing 0 to a flag bit clears it only if that bit read as 1 since the last status write. Writing 1 has no effect.
- R11: A read strobe returns the addressed register on bus_rdata, with bus_rvalid high, on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_src | input | 8 | Count-enable sources |
| cap_in | input | 4 | Capture pins, one per register |
| cmp_out | output | 4 | Compare output pins, one per register |
| flags | output | 5 | Event flags A..D and wrap flag |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| bus_rvalid | output | 1 | Read data valid |

## Verification
A bus write to the counter can land on the same edge as a compare match that clears the counter. The bench provokes this by loading the counter two counts below register A while the counter runs freely. It then idles so that the second counter write strikes exactly on the matching edge. The counter must then read 0 and not the written value. Each read is queued as an expected value when it is issued, and a monitor compares the returned data one cycle later.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int NREG = 4;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } cmp_act_e;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_MODE   = 3'd1,
    A_STATUS = 3'd2,
    A_COUNT  = 3'd3,
    A_GRA    = 3'd4,
    A_GRB    = 3'd5,
    A_GRC    = 3'd6,
    A_GRD    = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/cct_edge.sv
module cct_edge #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       evt
);
  logic [STAGES-1:0] sr;
  logic              prev;
  logic              last;

  assign last = sr[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      prev <= 1'b0;
    end else begin
      sr   <= {sr[STAGES-2:0], pin};
      prev <= last;
    end
  end

  // sel[0]: rising edge, sel[1]: falling edge
  assign evt = (last & ~prev & sel[0]) | (~last & prev & sel[1]);
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (wr)   cnt <= wdata;
    else if (tick) cnt <= cnt + 1'b1;
  end

  assign wrap = tick & (&cnt) & ~clr & ~wr;

  // R9: clear beats everything
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  // R9: write beats increment
  p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (wr && !clr) |=> (cnt == $past(wdata)));
  // R8: a wrap lands on zero
  p_wrap_zero_r8: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int W    = 16,
  parameter int NSRC = 8,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] tick_src,
  input  logic [3:0]      cap_in,
  output logic [3:0]      cmp_out,
  output logic [4:0]      flags,
  input  logic [2:0]      bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [W-1:0]    bus_wdata,
  output logic [W-1:0]    bus_rdata,
  output logic            bus_rvalid
);
  localparam int SELW = $clog2(NSRC);

  logic [W-1:0] ctrl, mode;
  logic [W-1:0] gr [NREG];
  logic [W-1:0] cnt;
  logic [4:0]   armed;
  logic [NREG-1:0] evt, match, cap, hit, is_buf, cap_mode;
  logic [SELW-1:0] clk_sel;
  logic [2:0]   csrc;
  logic [1:0]   buf_on;
  logic         tick, clr, wrap;

  assign clk_sel = ctrl[SELW-1:0];
  assign csrc    = ctrl[6:4];
  assign buf_on  = ctrl[9:8];
  assign tick    = tick_src[clk_sel];

  genvar i;
  generate
    for (i = 0; i < NREG; i++) begin : g_reg
      cct_edge #(.STAGES(SYNC)) u_edge (
        .clk (clk),
        .rst (rst),
        .pin (cap_in[i]),
        .sel (mode[4*i+1 +: 2]),
        .evt (evt[i])
      );
      if (i >= 2) begin : g_bufsel
        assign is_buf[i] = buf_on[i-2];
      end else begin : g_nobuf
        assign is_buf[i] = 1'b0;
      end
      assign cap_mode[i] = mode[4*i];
      assign match[i] = ~cap_mode[i] & ~is_buf[i] & tick & (cnt == gr[i]);
      assign cap[i]   =  cap_mode[i] & ~is_buf[i] & evt[i];
      assign hit[i]   = match[i] | cap[i];
    end
  endgenerate

  always_comb begin
    case (csrc)
      3'd1:    clr = hit[0];
      3'd2:    clr = hit[1];
      3'd3:    clr = hit[2];
      3'd4:    clr = hit[3];
      default: clr = 1'b0;
    endcase
  end

  cct_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .clr   (clr),
    .wr    (bus_wr && bus_addr == A_COUNT),
    .wdata (bus_wdata),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  // control, mode and general registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      mode <= '0;
      for (int k = 0; k < NREG; k++) gr[k] <= '1;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) ctrl <= bus_wdata;
      if (bus_wr && bus_addr == A_MODE) mode <= bus_wdata;
      for (int k = 0; k < NREG; k++)
        if (bus_wr && bus_addr == 3'(4 + k)) gr[k] <= bus_wdata;
      // events override bus writes
      for (int k = 0; k < 2; k++) begin
        if (cap[k]) begin
          gr[k] <= cnt;
          if (buf_on[k]) gr[k+2] <= gr[k];
        end else if (match[k] && buf_on[k]) begin
          gr[k] <= gr[k+2];
        end
      end
      for (int k = 2; k < NREG; k++)
        if (cap[k]) gr[k] <= cnt;
    end
  end

  // compare outputs
  always_ff @(posedge clk) begin
    if (rst) cmp_out <= '0;
    else begin
      for (int k = 0; k < NREG; k++) begin
        if (match[k]) begin
          case (cmp_act_e'(mode[4*k+1 +: 2]))
            ACT_LOW:    cmp_out[k] <= 1'b0;
            ACT_HIGH:   cmp_out[k] <= 1'b1;
            ACT_TOGGLE: cmp_out[k] <= ~cmp_out[k];
            default:    cmp_out[k] <= cmp_out[k];
          endcase
        end
      end
    end
  end

  // sticky flags with read-then-write-zero clearing
  logic st_wr, st_rd;
  assign st_wr = bus_wr && bus_addr == A_STATUS;
  assign st_rd = bus_rd && bus_addr == A_STATUS;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      armed <= '0;
    end else begin
      flags <= (flags & ~(st_wr ? (armed & ~bus_wdata[4:0]) : 5'd0)) | {wrap, hit};
      if (st_wr)      armed <= '0;
      else if (st_rd) armed <= armed | flags;
    end
  end

  // read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        case (reg_addr_e'(bus_addr))
          A_CTRL:   bus_rdata <= ctrl;
          A_MODE:   bus_rdata <= mode;
          A_STATUS: bus_rdata <= W'(flags);
          A_COUNT:  bus_rdata <= cnt;
          A_GRA:    bus_rdata <= gr[0];
          A_GRB:    bus_rdata <= gr[1];
          A_GRC:    bus_rdata <= gr[2];
          default:  bus_rdata <= gr[3];
        endcase
      end
    end
  end

  // R10: a flag only falls after a status write
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (|($past(flags) & ~flags)) |-> $past(st_wr));
  // R4: capture stores the counter
  p_capture_value_r4: assert property (@(posedge clk) disable iff (rst)
    cap[0] |=> (gr[0] == $past(cnt)));
  // R6: buffered compare reloads from the buffer
  p_buffer_load_r6: assert property (@(posedge clk) disable iff (rst)
    (match[0] && buf_on[0]) |=> (gr[0] == $past(gr[2])));
  // R3: drive-high action
  p_out_high_r3: assert property (@(posedge clk) disable iff (rst)
    (match[0] && mode[2:1] == 2'b10) |=> cmp_out[0]);
  // R11: read valid follows the strobe
  p_read_latency_r11: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
endmodule

// File: tb/sim_cct_timer.sv
module sim_cct_timer;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  tick_src = '0;
  logic [3:0]  cap_in = '0;
  logic [3:0]  cmp_out;
  logic [4:0]  flags;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] exp_q [$];
  logic [15:0] msk_q [$];
  string       tag_q [$];

  always #(PERIOD/2) clk = ~clk;

  cct_timer u0 (
    .clk(clk), .rst(rst), .tick_src(tick_src), .cap_in(cap_in),
    .cmp_out(cmp_out), .flags(flags), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] e,
                    input logic [15:0] m, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); msk_q.push_back(m); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run(input int n);
    tick_src = 8'hFF;
    repeat (n) @(negedge clk);
    tick_src = 8'h00;
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] e, input string tag);
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, e);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R11 unexpected read: got %h expected none", bus_rdata);
      end else begin
        logic [15:0] e, m;
        string t;
        e = exp_q.pop_front(); m = msk_q.pop_front(); t = tag_q.pop_front();
        if ((bus_rdata & m) !== (e & m)) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", t, bus_rdata & m, e & m);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1 reset state, R11 read latency
    chk(16'(cmp_out), 16'h0, "R1 cmp_out");
    chk(16'(flags), 16'h0, "R1 flags");
    rd(3'd3, 16'h0000, 16'hFFFF, "R1 counter");
    rd(3'd4, 16'hFFFF, 16'hFFFF, "R1 reg A");
    rd(3'd2, 16'h0000, 16'h001F, "R1 status");

    // R2 count source select
    wr(3'd0, 16'h0003);
    wr(3'd3, 16'h0000);
    tick_src = 8'hF7; idle(6);
    tick_src = 8'h08; idle(4);
    tick_src = 8'h00;
    rd(3'd3, 16'h0004, 16'hFFFF, "R2 counter");
    wr(3'd0, 16'h0000);

    // R3 compare actions: A high, B toggle, C hold, D high
    wr(3'd1, 16'h4064);
    wr(3'd4, 16'h0012); wr(3'd5, 16'h0012);
    wr(3'd6, 16'h0012); wr(3'd7, 16'h0012);
    wr(3'd3, 16'h0010);
    run(3);
    chk(16'(cmp_out), 16'h000B, "R3 outputs after first match");
    rd(3'd3, 16'h0013, 16'hFFFF, "R3 counter");
    rd(3'd2, 16'h000F, 16'h000F, "R3 flags");
    // R10 flag clearing protocol
    wr(3'd2, 16'hFFFE);
    wr(3'd2, 16'hFFF0);
    rd(3'd2, 16'h000E, 16'h000F, "R10 unarmed write ignored");
    wr(3'd2, 16'hFFF0);
    rd(3'd2, 16'h0000, 16'h000F, "R10 armed write clears");
    // R3 second match: D drive low, B toggles back
    wr(3'd1, 16'h2064);
    wr(3'd3, 16'h0012);
    run(1);
    chk(16'(cmp_out), 16'h0001, "R3 outputs after second match");

    // R4 capture: A rising, B falling, C/D none
    wr(3'd1, 16'h1153);
    tick_src = 8'hFF;
    cap_in[1] = 1'b1;
    idle(5);
    rd(3'd5, 16'h0012, 16'hFFFF, "R4 rising edge ignored on falling-only");
    wr(3'd3, 16'h0100);
    cap_in[0] = 1'b1; cap_in[1] = 1'b0;
    idle(4);
    rd(3'd4, 16'h0102, 16'hFFFF, "R4 rising capture value");
    rd(3'd5, 16'h0102, 16'hFFFF, "R4 falling capture value");
    rd(3'd2, 16'h0003, 16'h0003, "R4 capture flags");

    // R5 clear on capture of A
    wr(3'd0, 16'h0010);
    cap_in[0] = 1'b0;
    idle(4);
    wr(3'd3, 16'h0200);
    cap_in[0] = 1'b1;
    idle(3);
    rd(3'd3, 16'h0000, 16'hFFFF, "R5 counter cleared by capture");
    rd(3'd4, 16'h0202, 16'hFFFF, "R5 captured value");
    tick_src = 8'h00;

    // R6 buffered compare, clear on A
    wr(3'd0, 16'h0110);
    wr(3'd1, 16'h1150);
    wr(3'd4, 16'h0030); wr(3'd6, 16'h0050);
    wr(3'd3, 16'h0030);
    run(1);
    rd(3'd4, 16'h0050, 16'hFFFF, "R6 reload from buffer");
    rd(3'd6, 16'h0050, 16'hFFFF, "R6 buffer unchanged");
    rd(3'd3, 16'h0000, 16'hFFFF, "R5 clear on compare");

    // R7 buffered capture
    wr(3'd1, 16'h1153);
    wr(3'd0, 16'h0100);
    wr(3'd4, 16'h1111);
    cap_in[0] = 1'b0;
    idle(4);
    tick_src = 8'hFF;
    wr(3'd3, 16'h0400);
    cap_in[0] = 1'b1;
    idle(4);
    tick_src = 8'h00;
    rd(3'd4, 16'h0402, 16'hFFFF, "R7 new capture");
    rd(3'd6, 16'h1111, 16'hFFFF, "R7 old capture shifted");

    // R8 wrap flag
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'hFFFF);
    rd(3'd2, 16'h0000, 16'h0010, "R8 no wrap yet");
    run(1);
    rd(3'd3, 16'h0000, 16'hFFFF, "R8 counter wrapped");
    rd(3'd2, 16'h0010, 16'h0010, "R8 wrap flag");
    chk(16'(flags[4]), 16'h1, "R8 flag port");

    // R9 clear vs write in the same cycle, then write vs increment
    wr(3'd1, 16'h1150);
    wr(3'd0, 16'h0010);
    wr(3'd4, 16'h0020);
    tick_src = 8'hFF;
    wr(3'd3, 16'h001E);
    idle(2);
    wr(3'd3, 16'h1234);
    rd(3'd3, 16'h0000, 16'hFFFF, "R9 clear beats write");
    wr(3'd3, 16'h0500);
    rd(3'd3, 16'h0500, 16'hFFFF, "R9 write beats increment");
    tick_src = 8'h00;

    idle(4);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R11 missing reads: got %0d pending expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule